// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast input clock by N = B·P + A. A two-modulus prescaler divides the clock by either P or P+1. Two down-counters drive its modulus-control line: a 13-bit main count B and a 6-bit swallow count A. At the start of every output period the prescaler divides by P+1 until A prescaler periods have passed. It then divides by P for the remaining B − A periods. This gives A·(P+1) + (B − A)·P = B·P + A input clocks per output pulse.

The prescaler is a synchronous divide-by-4/5 stage followed by a small extension counter. The extension counter sets P to 8, 16, 32 or 64. The stage stretches to five input clocks only in the last four-clock slot of a prescaler period, and only while the modulus-control line is high. The block samples the prescaler select and the B and A presets only when a period ends. A change in the settings therefore never cuts an output period short. The block checks each setting as it arrives. It raises a flag for any setting it cannot realise, and it does not run on such a setting.

Top module: `pulse_swallow_divider`

## Requirements
- R1: Each output period lasts exactly N = B·P + A input clocks: `divPulse` rises once every N rising edges.
- R2: The select input `pscSel` picks the modulus pair: 0 gives 8/9, 1 gives 16/17, 2 gives 32/33 and 3 gives 64/65.
- R3: In each output period `modCtrl` is high for exactly A·(P+1) input clocks at the start of the period, and low for the rest.
- R4: `divPulse` is high for a single input clock per period.
- R5: `cfgInvalid` is high whenever the B preset is below 3.
- R6: `cfgInvalid` is high whenever the A preset is greater than the B preset. A = B is accepted.
- R7: `cfgInvalid` is high whenever B·P + A < P² − P. N = P² − P exactly is accepted.
- R8: If the presented setting is invalid when a period ends, that period still ends with its pulse. After it the block stays idle: no pulse, and `modCtrl` low.
- R9: A setting changed in the middle of a period takes effect only at the next period boundary. The current period keeps its old length.
- R10: While reset is low, `divPulse` and `modCtrl` are low. After reset releases with a legal setting presented, the first pulse follows the first rising edge by N edges.
- R11: From idle, the block loads a legal setting on the first rising edge at which it is presented. The first pulse comes N edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock to be divided |
| rstN | input | 1 | Asynchronous reset, active low |
| pscSel | input | 2 | Modulus pair select (0:8/9, 1:16/17, 2:32/33, 3:64/65) |
| bPreset | input | 13 | Main count B |
| aPreset | input | 6 | Swallow count A |
| divPulse | output | 1 | One-clock pulse per output period |
| modCtrl | output | 1 | High while the prescaler divides by P+1 |
| cfgInvalid | output | 1 | Presented setting is illegal (combinational) |

## Verification
`cfgInvalid` is combinational, so the bench reads it a fraction of a nanosecond after it changes the inputs, still within the same low clock phase. `divPulse` is registered. It shows up in the cycle after the rising edge that ends a period. A period loaded on edge e0 therefore pulses after edge eN, and a sample taken on the falling edge sees it N+1 falling edges after the setting was applied. Later intervals measure exactly N falling edges from one pulse to the next. Every check samples on the falling clock edge and counts these edges. For `modCtrl` the bench counts its high samples between two consecutive pulses.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
  // control-to-prescaler strobes
  typedef struct packed {
    logic       run;      // prescaler counting (held at zero otherwise)
    logic       modHigh;  // divide by P+1 in this prescaler period
    logic [1:0] sel;      // latched modulus pair select
  } pscCtrl_t;
endpackage

// File: rtl/fbdiv_prescaler.sv
module fbdiv_prescaler
  import fbdiv_pkg::*;
#(
  parameter int EXT_W = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  pscCtrl_t ctrl,
  output logic     pscTick
);
  logic [2:0]       coreCnt;
  logic [EXT_W-1:0] extCnt;
  logic [EXT_W-1:0] extMax;
  logic [2:0]       coreTop;
  logic             lastSlot;

  // P = 4 * 2^(sel+1): the extension counter spans 2^(sel+1) core slots
  always_comb begin
    extMax   = EXT_W'((2 << ctrl.sel) - 1);
    lastSlot = (extCnt == extMax);
    coreTop  = (ctrl.modHigh && lastSlot) ? 3'd4 : 3'd3;  // 4/5 core
    pscTick  = ctrl.run && lastSlot && (coreCnt == coreTop);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coreCnt <= '0;
      extCnt  <= '0;
    end else if (!ctrl.run) begin
      coreCnt <= '0;
      extCnt  <= '0;
    end else if (coreCnt == coreTop) begin
      coreCnt <= '0;
      extCnt  <= lastSlot ? '0 : extCnt + 1'b1;
    end else begin
      coreCnt <= coreCnt + 1'b1;
    end
  end

  assert_core_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    coreCnt <= 3'd4);
  assert_ext_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    extCnt <= extMax);
endmodule

// File: rtl/fbdiv_ctrl.sv
module fbdiv_ctrl
  import fbdiv_pkg::*;
#(
  parameter int BW = 13,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    pscSel,
  input  logic [BW-1:0] bPreset,
  input  logic [AW-1:0] aPreset,
  input  logic          pscTick,
  output pscCtrl_t      ctrl,
  output logic          divPulse,
  output logic          modCtrl,
  output logic          cfgInvalid
);
  localparam int NW = BW + 8;

  logic [NW-1:0] pVal, nVal, minN;
  logic [BW-1:0] bCnt;
  logic [AW-1:0] aCnt;
  logic [1:0]    selQ;
  logic          running;
  logic          expire;

  // legality of the presented setting
  always_comb begin
    pVal       = NW'(8) << pscSel;
    nVal       = NW'(bPreset) * pVal + NW'(aPreset);
    minN       = pVal * pVal - pVal;
    cfgInvalid = (bPreset < BW'(3)) || (BW'(aPreset) > bPreset) || (nVal < minN);
  end

  assign expire       = running && pscTick && (bCnt == BW'(1));
  assign modCtrl      = running && (aCnt != '0);
  assign ctrl.run     = running;
  assign ctrl.modHigh = modCtrl;
  assign ctrl.sel     = selQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running  <= 1'b0;
      bCnt     <= '0;
      aCnt     <= '0;
      selQ     <= '0;
      divPulse <= 1'b0;
    end else begin
      divPulse <= expire;
      if (!running || expire) begin
        if (cfgInvalid) begin
          running <= 1'b0;
          bCnt    <= '0;
          aCnt    <= '0;
        end else begin
          running <= 1'b1;
          bCnt    <= bPreset;
          aCnt    <= aPreset;
          selQ    <= pscSel;
        end
      end else if (pscTick) begin
        bCnt <= bCnt - 1'b1;
        if (aCnt != '0) aCnt <= aCnt - 1'b1;
      end
    end
  end

  assert_a_le_b_R6: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (BW'(aCnt) <= bCnt));
  assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rstN)
    divPulse |=> !divPulse);
  assert_pulse_src_R1: assert property (@(posedge clk) disable iff (!rstN)
    divPulse |-> $past(pscTick));
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (!pscTick && !modCtrl));
  assert_mod_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(modCtrl) |-> $past(pscTick));
endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider
  import fbdiv_pkg::*;
#(
  parameter int BW    = 13,
  parameter int AW    = 6,
  parameter int EXT_W = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    pscSel,
  input  logic [BW-1:0] bPreset,
  input  logic [AW-1:0] aPreset,
  output logic          divPulse,
  output logic          modCtrl,
  output logic          cfgInvalid
);
  pscCtrl_t pscCtrl;
  logic     pscTick;

  fbdiv_ctrl #(.BW(BW), .AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .pscSel(pscSel), .bPreset(bPreset),
    .aPreset(aPreset), .pscTick(pscTick), .ctrl(pscCtrl),
    .divPulse(divPulse), .modCtrl(modCtrl), .cfgInvalid(cfgInvalid)
  );

  fbdiv_prescaler #(.EXT_W(EXT_W)) u_psc (
    .clk(clk), .rstN(rstN), .ctrl(pscCtrl), .pscTick(pscTick)
  );
endmodule

// File: tb/pulse_swallow_divider_bench.sv
`timescale 1ns/1ps
module pulse_swallow_divider_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  pscSel = 2'd0;
  logic [12:0] bPreset = 13'd7;
  logic [5:0]  aPreset = 6'd0;
  logic        divPulse, modCtrl, cfgInvalid;

  int nChecks = 0;
  int nFails  = 0;
  int modCount;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  pulse_swallow_divider u_pulse_swallow_divider (
    .clk(clk), .rstN(rstN), .pscSel(pscSel), .bPreset(bPreset),
    .aPreset(aPreset), .divPulse(divPulse), .modCtrl(modCtrl),
    .cfgInvalid(cfgInvalid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setCfg(input int sel, input int b, input int a);
    pscSel = 2'(sel); bPreset = 13'(b); aPreset = 6'(a);
  endtask

  // counts falling edges until divPulse is seen; -1 on timeout
  task automatic waitPulse(input int limit, output int cyc);
    cyc = -1;
    modCount = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (modCtrl) modCount++;
      if (divPulse) begin cyc = i; break; end
    end
  endtask

  function automatic int nOf(input int sel, input int b, input int a);
    return b * (8 << sel) + a;
  endfunction

  task automatic testReset();
    int cyc;
    setCfg(0, 7, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(divPulse == 1'b0, "R10 pulse in reset", int'(divPulse), 0);
      check(modCtrl == 1'b0, "R10 modCtrl in reset", int'(modCtrl), 0);
    end
    rstN = 1'b1;
    waitPulse(200, cyc);
    check(cyc == 57, "R10 first pulse after reset", cyc, 57);
  endtask

  task automatic testRatio(input int sel, input int b, input int a, input string tag);
    int cyc, n;
    n = nOf(sel, b, a);
    setCfg(sel, b, a);
    waitPulse(5000, cyc);           // finish the old period
    waitPulse(n + 10, cyc);
    check(cyc == n, {tag, " R1 period"}, cyc, n);
    check(modCount == a * ((8 << sel) + 1), {tag, " R3 modCtrl span"}, modCount, a * ((8 << sel) + 1));
    @(negedge clk);
    check(divPulse == 1'b0, {tag, " R4 pulse width"}, int'(divPulse), 0);
    waitPulse(n + 10, cyc);
    check(cyc == n - 1, {tag, " R1 R2 second period"}, cyc, n - 1);
  endtask

  task automatic testFlags();
    // stay inside one low phase so no edge samples these values
    @(negedge clk);
    setCfg(0, 2, 0);   #0.2;
    check(cfgInvalid == 1'b1, "R5 B below 3", int'(cfgInvalid), 1);
    setCfg(0, 10, 11); #0.2;
    check(cfgInvalid == 1'b1, "R6 A above B", int'(cfgInvalid), 1);
    setCfg(0, 10, 10); #0.2;
    check(cfgInvalid == 1'b0, "R6 A equal B", int'(cfgInvalid), 0);
    setCfg(0, 6, 6);   #0.2;
    check(cfgInvalid == 1'b1, "R7 N 54 below 56", int'(cfgInvalid), 1);
    setCfg(0, 7, 0);   #0.2;
    check(cfgInvalid == 1'b0, "R7 N equal 56", int'(cfgInvalid), 0);
    setCfg(3, 62, 62); #0.2;
    check(cfgInvalid == 1'b1, "R7 N 4030 below 4032", int'(cfgInvalid), 1);
    setCfg(3, 63, 0);  #0.2;
    check(cfgInvalid == 1'b0, "R7 N equal 4032", int'(cfgInvalid), 0);
    setCfg(0, 9, 3);   #0.2;  // 75, the running setting's successor
  endtask

  task automatic testHoldRecover();
    int cyc, pulses, mods;
    waitPulse(5000, cyc);        // now on a boundary running 75
    setCfg(0, 2, 0);             // invalid
    waitPulse(200, cyc);
    check(cyc == 75, "R8 period in progress completes", cyc, 75);
    pulses = 0; mods = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (divPulse) pulses++;
      if (modCtrl) mods++;
    end
    check(pulses == 0, "R8 no pulse while invalid", pulses, 0);
    check(mods == 0, "R8 modCtrl low while invalid", mods, 0);
    setCfg(0, 9, 3);
    waitPulse(200, cyc);
    check(cyc == 76, "R11 restart from idle", cyc, 76);
  endtask

  task automatic testBoundary();
    int cyc;
    for (int i = 0; i < 10; i++) @(negedge clk);
    setCfg(1, 20, 4);            // 324, applied mid period of 75
    waitPulse(200, cyc);
    check(cyc == 65, "R9 current period keeps old length", cyc, 65);
    waitPulse(400, cyc);
    check(cyc == 324, "R9 new length from boundary", cyc, 324);
  endtask

  initial begin
    testReset();
    testRatio(0, 7, 0, "P8 B7 A0");
    testRatio(0, 10, 5, "P8 B10 A5");
    testRatio(1, 20, 15, "P16 B20 A15");
    testRatio(2, 31, 31, "P32 B31 A31");
    testRatio(3, 63, 2, "P64 B63 A2");
    setCfg(0, 9, 3);
    testFlags();
    testHoldRecover();
    testBoundary();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule